// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block fronts the enhanced-mode address and data registers of a parallel port. A CPU access to one of these registers becomes one or more external byte cycles, but only when the port's control register holds the idle pattern that the requested direction needs. An access made under any other control pattern is dropped. No external cycle is requested, and the access finishes on the next clock. The data register takes 1-, 2- or 4-byte accesses and splits them into byte cycles, lowest byte first. The address register always moves one byte.

Each byte cycle is a request/acknowledge handshake. A byte that is not acknowledged within a programmable number of clocks ends the whole access and sets a sticky timeout flag. The flag appears as bit 0 of the status register, in place of the line value for that bit. Software clears it by writing the status register with bit 0 set. The CPU sees `acc_busy` while byte cycles are in flight and a one-cycle `acc_done` pulse when the access ends. Read data is valid with that pulse.

Top module: `epp_xfer_gate`

## Requirements
- R1: A write to offset 3 or 4 issues byte cycles only if (port_ctl & 0x2F) == 0x04. Any other value drops the write. Control bits outside mask 0x2F have no effect.
- R2: A read from offset 3 or 4 issues byte cycles only if (port_ctl & 0x2F) == 0x24. Any other value drops the read.
- R3: A dropped access asserts no cyc_req and raises acc_done on the clock after acceptance. A dropped read returns ones in every byte of its width, zeros above that. A dropped write returns 0.
- R4: Width encoding in acc_size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Offset 3 always moves 1 byte and drives cyc_addr = 1. Offset 4 drives cyc_addr = 0. A write puts acc_wdata bytes on cyc_wbyte lowest byte first, with cyc_write = 1.
- R5: A read places the k-th acknowledged byte in acc_rdata[8k+7:8k].
- R6: A byte whose request sees no cyc_ack during its first tmo_limit+1 clocks aborts the access. The abort sets the timeout flag and issues no further bytes. Bytes of a read that were not received read as 0xFF.
- R7: A status read (offset 1) returns line_status with bit 0 replaced by the timeout flag.
- R8: A status write with bit 0 set clears the timeout flag. With bit 0 clear it leaves the flag unchanged.
- R9: acc_busy is high from the clock after an accepted cycle-issuing access until acc_done. acc_valid while busy is ignored.
- R10: After reset the block is idle with acc_done = 0, acc_rdata = 0, cyc_req = 0 and the timeout flag clear.
- R11: Accesses to any other offset complete on the next clock with acc_rdata = 0 and issue no byte cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | CPU access strobe, taken when not busy |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_off | input | 3 | Register offset |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | DW | Write data |
| acc_busy | output | 1 | Byte cycles in progress |
| acc_done | output | 1 | One-cycle completion pulse |
| acc_rdata | output | DW | Read result, valid with acc_done |
| port_ctl | input | 8 | Current control register value |
| line_status | input | 8 | Status lines from the port |
| tmo_limit | input | TW | Per-byte acknowledge window minus one, in clocks |
| cyc_req | output | 1 | External byte cycle request |
| cyc_write | output | 1 | Byte cycle direction, 1 = write |
| cyc_addr | output | 1 | 1 = address cycle, 0 = data cycle |
| cyc_wbyte | output | 8 | Byte being written |
| cyc_ack | input | 1 | One-cycle acknowledge of the current byte |
| cyc_rbyte | input | 8 | Byte returned with cyc_ack |

## Verification
Every result is due at a fixed distance from the clock edge that causes it:
- Dropped accesses, status accesses and other offsets report `acc_done` one edge after acceptance.
- The first byte request appears one edge after acceptance.
- Each further byte request appears one edge after the acknowledge of the previous byte.
- A timeout ends the access tmo_limit+1 clocks after that byte's request began.

A behavioural model in the bench advances on the same edges as the design. Its state is compared with the design's outputs half a period after each edge, so each result is checked in the cycle it is due and never earlier. Directed checks then confirm, at the ports, the byte order, the fill values, the flag state and the bytes the responder collected.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;
  // direction | select | init | autofeed | strobe
  localparam logic [7:0] CTL_MASK    = 8'h2F;
  localparam logic [7:0] CTL_WR_IDLE = 8'h04;
  localparam logic [7:0] CTL_RD_IDLE = 8'h24;

  typedef enum logic {ST_IDLE, ST_XFER} gate_st_e;
endpackage

// File: rtl/epp_gate_decode.sv
module epp_gate_decode
  import epp_gate_pkg::*;
#(
  parameter int NB = 4,
  parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [7:0]    port_ctl,
  input  logic          is_write,
  input  logic [2:0]    off,
  input  logic [1:0]    size,
  output logic          is_epp,
  output logic          allow,
  output logic [IW-1:0] last_idx
);
  logic [7:0] masked;
  int         req_bytes;

  always_comb begin
    masked = port_ctl & CTL_MASK;
    is_epp = (off == OFF_EADDR) || (off == OFF_EDATA);
    allow  = is_write ? (masked == CTL_WR_IDLE) : (masked == CTL_RD_IDLE);
    if (off == OFF_EADDR) begin
      req_bytes = 1;
    end else begin
      case (size)
        2'd0:    req_bytes = 1;
        2'd1:    req_bytes = 2;
        default: req_bytes = 4;
      endcase
    end
    if (req_bytes > NB) req_bytes = NB;
    last_idx = IW'(req_bytes - 1);
  end
endmodule

// File: rtl/epp_byte_timer.sv
module epp_byte_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ack,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    expired = run && !ack && (cnt_q >= limit);
    if (!run || ack || expired) cnt_n = '0;
    else                        cnt_n = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R6: after an expiry the next byte window starts from zero
  p_window_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (cnt_q == '0));
endmodule

// File: rtl/epp_lane_mux.sv
module epp_lane_mux #(
  parameter int NB = 4,
  parameter int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [8*NB-1:0] wdata,
  input  logic [8*NB-1:0] rdata,
  input  logic [IW-1:0]   idx,
  input  logic [7:0]      rbyte,
  output logic [7:0]      wbyte,
  output logic [8*NB-1:0] merged
);
  assign wbyte = wdata[8*idx +: 8];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign merged[8*g +: 8] = (idx == IW'(g)) ? rbyte : rdata[8*g +: 8];
  end
endmodule

// File: rtl/epp_xfer_gate.sv
module epp_xfer_gate
  import epp_gate_pkg::*;
#(
  parameter int DW = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [2:0]    acc_off,
  input  logic [1:0]    acc_size,
  input  logic [DW-1:0] acc_wdata,
  output logic          acc_busy,
  output logic          acc_done,
  output logic [DW-1:0] acc_rdata,
  input  logic [7:0]    port_ctl,
  input  logic [7:0]    line_status,
  input  logic [TW-1:0] tmo_limit,
  output logic          cyc_req,
  output logic          cyc_write,
  output logic          cyc_addr,
  output logic [7:0]    cyc_wbyte,
  input  logic          cyc_ack,
  input  logic [7:0]    cyc_rbyte
);
  localparam int NB = DW / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  gate_st_e      st_q, st_n;
  logic [IW-1:0] idx_q, idx_n, last_q, last_n;
  logic          wr_q, wr_n, ad_q, ad_n;
  logic [DW-1:0] wdata_q, rdata_q, rdata_n;
  logic          done_q, done_n, flag_q, flag_n, ld_wdata;

  logic          dec_is_epp, dec_allow, expired, accept;
  logic [IW-1:0] dec_last;
  logic [DW-1:0] fill_ones, merged;

  epp_gate_decode #(.NB(NB), .IW(IW)) u_dec (
    .port_ctl (port_ctl),
    .is_write (acc_write),
    .off      (acc_off),
    .size     (acc_size),
    .is_epp   (dec_is_epp),
    .allow    (dec_allow),
    .last_idx (dec_last)
  );

  epp_byte_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == ST_XFER),
    .ack     (cyc_ack),
    .limit   (tmo_limit),
    .expired (expired)
  );

  epp_lane_mux #(.NB(NB), .IW(IW)) u_lane (
    .wdata  (wdata_q),
    .rdata  (rdata_q),
    .idx    (idx_q),
    .rbyte  (cyc_rbyte),
    .wbyte  (cyc_wbyte),
    .merged (merged)
  );

  always_comb begin
    for (int k = 0; k < NB; k++)
      fill_ones[8*k +: 8] = (k <= int'(dec_last)) ? 8'hFF : 8'h00;
  end

  assign accept = acc_valid && (st_q == ST_IDLE);

  // next state
  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    last_n   = last_q;
    wr_n     = wr_q;
    ad_n     = ad_q;
    rdata_n  = rdata_q;
    flag_n   = flag_q;
    done_n   = 1'b0;
    ld_wdata = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (acc_valid) begin
          done_n  = 1'b1;
          rdata_n = '0;
          if (acc_off == OFF_STAT) begin
            if (acc_write) begin
              if (acc_wdata[0]) flag_n = 1'b0;
            end else begin
              rdata_n[7:0] = (line_status & 8'hFE) | {7'b0, flag_q};
            end
          end else if (dec_is_epp) begin
            if (!acc_write) rdata_n = fill_ones;
            if (dec_allow) begin
              st_n     = ST_XFER;
              done_n   = 1'b0;
              idx_n    = '0;
              last_n   = dec_last;
              wr_n     = acc_write;
              ad_n     = (acc_off == OFF_EADDR);
              ld_wdata = 1'b1;
            end
          end
        end
      end
      ST_XFER: begin
        if (cyc_ack) begin
          if (!wr_q) rdata_n = merged;
          if (idx_q == last_q) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            idx_n = idx_q + IW'(1);
          end
        end else if (expired) begin
          flag_n = 1'b1;
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      ad_q    <= 1'b0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      last_q  <= last_n;
      wr_q    <= wr_n;
      ad_q    <= ad_n;
      rdata_q <= rdata_n;
      done_q  <= done_n;
      flag_q  <= flag_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdata_q <= '0;
    else if (ld_wdata) wdata_q <= acc_wdata;
  end

  assign acc_busy  = (st_q == ST_XFER);
  assign cyc_req   = (st_q == ST_XFER);
  assign cyc_write = wr_q;
  assign cyc_addr  = ad_q;
  assign acc_done  = done_q;
  assign acc_rdata = rdata_q;

  // R3: a refused enhanced access never raises a request and ends at once
  p_drop_no_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_is_epp && !dec_allow) |=> (!cyc_req && acc_done));

  // R1: a granted access starts with byte 0 on the next clock
  p_grant_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_is_epp && dec_allow) |=> (cyc_req && idx_q == '0));

  // R9: an unanswered byte holds its request and lane
  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !cyc_ack && !expired) |=> (cyc_req && $stable(idx_q)));

  // R6: an expiry ends the access and leaves the flag set
  p_tmo_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (flag_q && acc_done && !cyc_req));

  // R8: a status write with bit 0 set clears the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_off == OFF_STAT && acc_write && acc_wdata[0]) |=> !flag_q);
endmodule

// File: tb/epp_xfer_gate_bench.sv
module epp_xfer_gate_bench;
  localparam int DW = 32;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0]    acc_off = '0;
  logic [1:0]    acc_size = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic          acc_busy, acc_done;
  logic [DW-1:0] acc_rdata;
  logic [7:0]    port_ctl = 8'h0C, line_status = 8'hAB;
  logic [TW-1:0] tmo_limit = 8'd5;
  logic          cyc_req, cyc_write, cyc_addr;
  logic [7:0]    cyc_wbyte;
  logic          cyc_ack = 1'b0;
  logic [7:0]    cyc_rbyte = '0;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  epp_xfer_gate #(.DW(DW), .TW(TW)) u_epp_xfer_gate (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_off(acc_off), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_busy(acc_busy), .acc_done(acc_done), .acc_rdata(acc_rdata),
    .port_ctl(port_ctl), .line_status(line_status), .tmo_limit(tmo_limit),
    .cyc_req(cyc_req), .cyc_write(cyc_write), .cyc_addr(cyc_addr),
    .cyc_wbyte(cyc_wbyte), .cyc_ack(cyc_ack), .cyc_rbyte(cyc_rbyte)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_busy, m_done, m_flag, m_write, m_addr;
  int        m_idx, m_cnt, m_n;
  logic [31:0] m_rdata, m_wdata;

  function automatic logic [31:0] ones(input int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 32'd1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_flag = 0; m_rdata = '0;
      m_idx = 0; m_cnt = 0; m_n = 1; m_write = 0; m_addr = 0; m_wdata = '0;
    end else if (!m_busy) begin
      m_done = 0;
      if (acc_valid) begin
        m_done = 1;
        if (acc_off == 3'd1) begin
          if (acc_write) begin m_rdata = '0; if (acc_wdata[0]) m_flag = 0; end
          else m_rdata = {24'd0, line_status[7:1], m_flag};
        end else if (acc_off == 3'd3 || acc_off == 3'd4) begin
          bit ok;
          m_n = (acc_off == 3'd3) ? 1 : (acc_size == 2'd0) ? 1 : (acc_size == 2'd1) ? 2 : 4;
          ok = acc_write ? ((port_ctl & 8'h2F) == 8'h04) : ((port_ctl & 8'h2F) == 8'h24);
          m_rdata = acc_write ? 32'd0 : ones(m_n);
          if (ok) begin
            m_done = 0; m_busy = 1; m_idx = 0; m_cnt = 0;
            m_write = acc_write; m_addr = (acc_off == 3'd3); m_wdata = acc_wdata;
          end
        end else begin
          m_rdata = '0;
        end
      end
    end else begin
      m_done = 0;
      if (cyc_ack) begin
        if (!m_write) m_rdata[8*m_idx +: 8] = cyc_rbyte;
        if (m_idx == m_n - 1) begin m_busy = 0; m_done = 1; end
        else begin m_idx++; m_cnt = 0; end
      end else if (m_cnt >= int'(tmo_limit)) begin
        m_flag = 1; m_busy = 0; m_done = 1;
      end else begin
        m_cnt++;
      end
    end
  end

  // every-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(acc_busy == m_busy, "R9 busy", {31'd0, acc_busy}, {31'd0, m_busy});
      chk(cyc_req == m_busy, "R1/R2 cyc_req", {31'd0, cyc_req}, {31'd0, m_busy});
      chk(acc_done == m_done, "R3 acc_done", {31'd0, acc_done}, {31'd0, m_done});
      if (m_done) chk(acc_rdata == m_rdata, "R5 acc_rdata", acc_rdata, m_rdata);
      if (m_busy) begin
        chk(cyc_write == m_write, "R4 cyc_write", {31'd0, cyc_write}, {31'd0, m_write});
        chk(cyc_addr == m_addr, "R4 cyc_addr", {31'd0, cyc_addr}, {31'd0, m_addr});
        if (m_write)
          chk(cyc_wbyte == m_wdata[8*m_idx +: 8], "R4 cyc_wbyte", {24'd0, cyc_wbyte},
              {24'd0, m_wdata[8*m_idx +: 8]});
      end
    end
  end

  // ---------------- external responder ----------------
  int   resp_lat = 1, resp_left = -1, wait_c = 0, acks = 0;
  logic [7:0] resp_base = 8'hA0;
  logic [7:0] seen [$];
  bit   seen_addr;

  always @(negedge clk) begin
    if (cyc_ack) begin
      cyc_ack <= 1'b0;
    end else if (rst_n && cyc_req && resp_left != 0) begin
      if (wait_c >= resp_lat) begin
        cyc_ack   <= 1'b1;
        cyc_rbyte <= resp_base + 8'(acks);
        seen.push_back(cyc_wbyte);
        seen_addr = cyc_addr;
        acks++;
        if (resp_left > 0) resp_left--;
        wait_c = 0;
      end else begin
        wait_c++;
      end
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] res;

  task automatic prep(input int lat, input int left);
    seen.delete(); acks = 0; wait_c = 0; resp_lat = lat; resp_left = left;
  endtask

  task automatic access(input logic [2:0] off, input bit wr, input logic [1:0] sz,
                        input logic [31:0] wd, input bit extra = 1'b0);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_off = off; acc_size = sz; acc_wdata = wd;
    @(negedge clk);
    if (extra) begin
      acc_off = 3'd1; acc_write = 1'b1; acc_wdata = 32'd1;
    end else begin
      acc_valid = 1'b0;
    end
    for (int i = 0; i < 400; i++) begin
      if (acc_done) break;
      @(negedge clk);
    end
    acc_valid = 1'b0;
    res = acc_rdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired R9 act=%h exp=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_busy == 1'b0 && cyc_req == 1'b0, "R10 idle in reset", {30'd0, acc_busy, cyc_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_done == 1'b0 && acc_rdata == '0, "R10 reset outputs", acc_rdata, 32'd0);

    // R1/R4: address write, one byte, address cycle
    port_ctl = 8'h04; prep(1, -1);
    access(3'd3, 1'b1, 2'd2, 32'hDEAD_BE5A);
    chk(seen.size() == 1 && seen[0] == 8'h5A && seen_addr, "R4 addr write one byte",
        {24'd0, seen[0]}, 32'h5A);

    // R4: 32-bit data write lowest byte first; bits outside mask ignored (R1)
    port_ctl = 8'hC4; prep(0, -1);
    access(3'd4, 1'b1, 2'd2, 32'h1122_3344);
    chk(seen.size() == 4 && seen[0] == 8'h44 && seen[1] == 8'h33 && seen[2] == 8'h22
        && seen[3] == 8'h11 && !seen_addr, "R1 R4 wide write order",
        {seen[3], seen[2], seen[1], seen[0]}, 32'h1122_3344);

    // R1/R3: write under wrong patterns is dropped
    port_ctl = 8'h0C; prep(0, -1);
    access(3'd4, 1'b1, 2'd1, 32'h0000_7777);
    chk(acks == 0 && res == 32'd0, "R1 R3 write dropped select", acks, 0);
    port_ctl = 8'h24; prep(0, -1);
    access(3'd3, 1'b1, 2'd0, 32'h55);
    chk(acks == 0, "R1 write dropped in read pattern", acks, 0);

    // R2/R5: 16-bit read
    port_ctl = 8'h24; prep(2, -1); resp_base = 8'h30;
    access(3'd4, 1'b0, 2'd1, 32'd0);
    chk(res == 32'h0000_3130, "R2 R5 16-bit read", res, 32'h0000_3130);
    // R2: address read
    prep(0, -1); resp_base = 8'h77;
    access(3'd3, 1'b0, 2'd2, 32'd0);
    chk(res == 32'h0000_0077 && seen_addr, "R2 R4 addr read", res, 32'h77);

    // R3: reads dropped in write pattern return ones of their width
    port_ctl = 8'h04; prep(0, -1);
    access(3'd4, 1'b0, 2'd2, 32'd0);
    chk(res == 32'hFFFF_FFFF && acks == 0, "R3 dropped 32-bit read", res, 32'hFFFF_FFFF);
    access(3'd4, 1'b0, 2'd0, 32'd0);
    chk(res == 32'h0000_00FF, "R3 dropped 8-bit read", res, 32'hFF);

    // R7: status read, flag clear
    access(3'd1, 1'b0, 2'd0, 32'd0);
    chk(res == 32'h0000_00AA, "R7 status flag clear", res, 32'hAA);

    // R6: one byte answered then silence, 32-bit read aborts
    port_ctl = 8'h24; prep(0, 1); resp_base = 8'h5C;
    access(3'd4, 1'b0, 2'd2, 32'd0);
    chk(res == 32'hFFFF_FF5C, "R6 partial read fill", res, 32'hFFFF_FF5C);
    line_status = 8'h40;
    access(3'd1, 1'b0, 2'd0, 32'd0);
    chk(res == 32'h0000_0041, "R6 R7 flag set in status", res, 32'h41);

    // R9: status clear presented while busy is ignored
    port_ctl = 8'h04; prep(1, -1);
    access(3'd4, 1'b1, 2'd2, 32'hCAFE_F00D, 1'b1);
    chk(acks == 4, "R9 bytes of busy access", acks, 4);
    access(3'd1, 1'b0, 2'd0, 32'd0);
    chk(res[0] == 1'b1, "R9 clear during busy ignored", res, 32'h41);

    // R8: bit 0 clear keeps flag, bit 0 set clears it
    access(3'd1, 1'b1, 2'd0, 32'hFE);
    access(3'd1, 1'b0, 2'd0, 32'd0);
    chk(res[0] == 1'b1, "R8 write without bit0 keeps flag", res, 32'h41);
    access(3'd1, 1'b1, 2'd0, 32'h01);
    access(3'd1, 1'b0, 2'd0, 32'd0);
    chk(res == 32'h0000_0040, "R8 flag cleared", res, 32'h40);

    // R6: a byte with no answer at all, 8-bit read
    port_ctl = 8'h24; prep(0, 0); tmo_limit = 8'd2;
    access(3'd4, 1'b0, 2'd0, 32'd0);
    chk(res == 32'h0000_00FF && acks == 0, "R6 no-answer read", res, 32'hFF);

    // R11: other offset
    prep(0, -1);
    access(3'd0, 1'b0, 2'd0, 32'd0);
    chk(res == 32'd0 && acks == 0, "R11 other offset", res, 32'd0);
    access(3'd2, 1'b1, 2'd0, 32'hFF);
    chk(acks == 0, "R11 other offset write", acks, 0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule